// File: doc/BRIEF.md
# Load and Battery Fault Supervisor

This block sits between the channel on/off commands of a four-channel low-side predriver and its gate drive outputs. It watches one digital drain comparison per channel and uses the channel's commanded state to decide what that comparison means. A drain that stays high while the channel is commanded on is read as a shorted load. A drain that stays low while the channel is commanded off is read as an open load. Both readings are deglitched in system clocks before they count as faults.

A shorted channel is not latched off. Its drive is replaced by a low-duty PWM waveform, and the short is re-tested during each on phase. Normal drive returns as soon as an on phase shows a healthy drain. The live per-channel load-fault bits go to the serial interface. The active-low global flag collects load faults and battery faults.

A battery over-voltage or under-voltage level takes priority over all of this. It turns every channel off, pulls the global flag low, and clears and masks the load-fault bits. Load-fault detection starts again from zero once the battery level is back in range.

Top module: `load_fault_supervisor`

## Requirements
- R1: With no fault present, drive[i] equals the cmd_on[i] value sampled at the previous clock edge. A channel that is commanded off is never driven.
- R2: load_flt[i] for a short sets at the edge where cmd_on[i]=1 and drain_hi[i]=1 (drain above the reference) have been sampled at SHORT_DG edges in a row. Any edge that samples drain_hi[i]=0 restarts the count, so shorter bursts are never reported.
- R3: While a short is flagged, drive[i] follows a PWM of period PWM_PER edges. It is high for the first PWM_ON edges of each period, and the first period starts at the edge where the flag sets.
- R4: A flagged short clears at the first edge whose PWM phase is "on" and whose sampled drain_hi[i] is 0, and normal drive resumes at that edge. Low drain readings during the off phase are ignored. Commanding the channel off clears the short at the next edge.
- R5: load_flt[i] for an open load sets after OPEN_DG consecutive edges that sample cmd_on[i]=0 and drain_hi[i]=0. It clears at the first edge that samples drain_hi[i]=1. A low drain lasting fewer than OPEN_DG edges after turn-off is not reported.
- R6: An open-load fault has no effect on drive[i], which stays 0.
- R7: When bat_ov or bat_uv is 1 at an edge, every drive bit is 0 after that edge, whatever cmd_on is, and fault_n is 0.
- R8: During a battery fault every load_flt bit is 0; battery faults never appear in load_flt. After the battery level returns to range, short and open deglitching restart from zero.
- R9: fault_n is 0 whenever any load_flt bit is 1, and 1 when no load fault and no battery fault was sampled at the last edge.
- R10: While rst is high, drive is 0, load_flt is 0 and fault_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | N_CH | Per-channel on command (1 = on) |
| drain_hi | input | N_CH | Per-channel drain comparison, 1 = drain above reference |
| bat_ov | input | 1 | Battery over-voltage comparator level |
| bat_uv | input | 1 | Battery under-voltage comparator level |
| drive | output | N_CH | Gate drive to the external switches |
| load_flt | output | N_CH | Live load-fault bits for the serial interface, bit i = channel i |
| fault_n | output | 1 | Global fault flag, active low |

## Verification
All outputs are registered from the values sampled at one edge, so each response is due exactly one edge after its stimulus. The deglitch thresholds add their counts on top of that: a short flags at edge SHORT_DG and an open at edge OPEN_DG, counted from the first edge that samples the condition. The bench applies inputs just after an edge and samples one time unit after each following edge. It counts edges from the start of every scenario and computes the expected flag, PWM phase ((k-SHORT_DG) mod PWM_PER < PWM_ON) and recovery edge (SHORT_DG+PWM_PER+1 for a drop in the off phase) from that count.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  // Counter width able to hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lfs_deglitch.sv
// Consecutive-hit qualifier: flag sets after DG evaluated hits in a row,
// drops on an evaluated miss, and is forced clear by clr.
module lfs_deglitch #(
  parameter int DG = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic eval,
  input  logic hit,
  output logic flag,
  output logic flag_nx
);
  import lfs_pkg::*;

  localparam int CW = cnt_w(DG);
  localparam logic [CW-1:0] LAST = CW'(DG - 1);

  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx  = cnt;
    flag_nx = flag;
    if (clr) begin
      cnt_nx  = '0;
      flag_nx = 1'b0;
    end else if (eval) begin
      if (hit) begin
        if (!flag) begin
          if (cnt == LAST) begin
            flag_nx = 1'b1;
            cnt_nx  = '0;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
      end else begin
        cnt_nx  = '0;
        flag_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      flag <= flag_nx;
    end
  end

  // R2, R5: a flag can only rise after a qualifying hit was sampled
  a_r2_flag_needs_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit && eval && !clr));

  // R2, R5: counter never passes its terminal value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/lfs_pwm.sv
// Fault PWM timebase: restarts at phase 0 on start, runs while run is high.
module lfs_pwm #(
  parameter int PER = 32,
  parameter int ON  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic start,
  output logic on_q,
  output logic on_nx
);
  import lfs_pkg::*;

  localparam int PW = cnt_w(PER);
  localparam logic [PW-1:0] WRAP = PW'(PER - 1);

  logic [PW-1:0] cnt, cnt_nx;

  always_comb begin
    if (!run || start)  cnt_nx = '0;
    else if (cnt == WRAP) cnt_nx = '0;
    else                  cnt_nx = cnt + 1'b1;
  end

  assign on_nx = (int'(cnt_nx) < ON);
  assign on_q  = (int'(cnt) < ON);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  // R3: phase counter stays inside one period
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < PER);

  // R3: a fresh start always lands in the on phase
  a_r3_start_phase: assert property (@(posedge clk) disable iff (rst)
    (start && run) |=> on_q);

endmodule

// File: rtl/lfs_channel.sv
// One channel: state-dependent short/open classification and PWM substitution.
module lfs_channel #(
  parameter int SHORT_DG = 8,
  parameter int OPEN_DG  = 4,
  parameter int PWM_PER  = 32,
  parameter int PWM_ON   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bat,
  input  logic cmd,
  input  logic drain_hi,
  output logic drive,
  output logic flt,
  output logic flt_nx
);

  logic sh_flag, sh_nx, op_flag, op_nx;
  logic pwm_on_q, pwm_on_nx;

  // Shorted load: commanded on with drain high; re-tested only in PWM on phase.
  lfs_deglitch #(.DG(SHORT_DG)) u_short (
    .clk     (clk),
    .rst     (rst),
    .clr     (bat || !cmd),
    .eval    (!sh_flag || pwm_on_q),
    .hit     (drain_hi),
    .flag    (sh_flag),
    .flag_nx (sh_nx)
  );

  // Open load: commanded off with drain low.
  lfs_deglitch #(.DG(OPEN_DG)) u_open (
    .clk     (clk),
    .rst     (rst),
    .clr     (bat || cmd),
    .eval    (1'b1),
    .hit     (!drain_hi),
    .flag    (op_flag),
    .flag_nx (op_nx)
  );

  lfs_pwm #(.PER(PWM_PER), .ON(PWM_ON)) u_pwm (
    .clk   (clk),
    .rst   (rst),
    .run   (sh_nx),
    .start (sh_nx && !sh_flag),
    .on_q  (pwm_on_q),
    .on_nx (pwm_on_nx)
  );

  assign flt_nx = sh_nx || op_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive <= 1'b0;
      flt   <= 1'b0;
    end else begin
      drive <= cmd && !bat && (!sh_nx || pwm_on_nx);
      flt   <= flt_nx;
    end
  end

  // R1: an uncommanded channel is never driven
  a_r1_off_no_drive: assert property (@(posedge clk) disable iff (rst)
    !cmd |=> !drive);

  // R6: an open-load fault coexists only with an undriven gate
  a_r6_open_no_drive: assert property (@(posedge clk) disable iff (rst)
    op_flag |-> !drive);

  // R4: turning the channel off drops a short flag at the next edge
  a_r4_off_clears_short: assert property (@(posedge clk) disable iff (rst)
    (sh_flag && !cmd) |=> !sh_flag);

  // R5: short and open are mutually exclusive classifications
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sh_flag && op_flag));

endmodule

// File: rtl/load_fault_supervisor.sv
module load_fault_supervisor #(
  parameter int N_CH     = 4,
  parameter int SHORT_DG = 8,
  parameter int OPEN_DG  = 4,
  parameter int PWM_PER  = 32,
  parameter int PWM_ON   = PWM_PER / 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] cmd_on,
  input  logic [N_CH-1:0] drain_hi,
  input  logic            bat_ov,
  input  logic            bat_uv,
  output logic [N_CH-1:0] drive,
  output logic [N_CH-1:0] load_flt,
  output logic            fault_n
);

  logic            bat;
  logic [N_CH-1:0] flt_nx;

  assign bat = bat_ov || bat_uv;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    lfs_channel #(
      .SHORT_DG (SHORT_DG),
      .OPEN_DG  (OPEN_DG),
      .PWM_PER  (PWM_PER),
      .PWM_ON   (PWM_ON)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .bat      (bat),
      .cmd      (cmd_on[i]),
      .drain_hi (drain_hi[i]),
      .drive    (drive[i]),
      .flt      (load_flt[i]),
      .flt_nx   (flt_nx[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= !(bat || (|flt_nx));
  end

  // R7: battery fault turns every channel off and pulls the flag low
  a_r7_bat_drive_off: assert property (@(posedge clk) disable iff (rst)
    bat |=> (drive == '0) && !fault_n);

  // R8: battery fault masks every load-fault bit
  a_r8_bat_mask: assert property (@(posedge clk) disable iff (rst)
    bat |=> (load_flt == '0));

  // R9: any reported load fault shows on the global flag
  a_r9_flag_follows: assert property (@(posedge clk) disable iff (rst)
    (|load_flt) |-> !fault_n);

endmodule

// File: tb/sim_load_fault_supervisor.sv
`timescale 1ns/1ps
module sim_load_fault_supervisor;

  localparam int NC  = 4;
  localparam int SDG = 5;
  localparam int ODG = 3;
  localparam int PER = 16;
  localparam int ON  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cmd_on = '0;
  logic [NC-1:0] drain_hi = '1;
  logic          bat_ov = 1'b0;
  logic          bat_uv = 1'b0;
  logic [NC-1:0] drive, load_flt;
  logic          fault_n;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  load_fault_supervisor #(
    .N_CH(NC), .SHORT_DG(SDG), .OPEN_DG(ODG), .PWM_PER(PER), .PWM_ON(ON)
  ) u0 (
    .clk(clk), .rst(rst), .cmd_on(cmd_on), .drain_hi(drain_hi),
    .bat_ov(bat_ov), .bat_uv(bat_uv),
    .drive(drive), .load_flt(load_flt), .fault_n(fault_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    cmd_on = '0; drain_hi = '1; bat_ov = 1'b0; bat_uv = 1'b0;
    step(); step();
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state even with fault-provoking inputs
    rst = 1'b1; cmd_on = '1; drain_hi = '1;
    step(); step();
    chk("R10 drive", drive, 0);
    chk("R10 load_flt", load_flt, 0);
    chk("R10 fault_n", fault_n, 1);
    cmd_on = '0; drain_hi = '1;
    step();
    rst = 1'b0;
    step();

    // R1: every command pattern with healthy drains
    for (int v = 0; v < 16; v++) begin
      cmd_on = 4'(v); drain_hi = ~4'(v);
      for (int k = 1; k <= SDG + ODG; k++) begin
        step();
        chk("R1 drive", drive, v);
        chk("R1 load_flt", load_flt, 0);
        chk("R9 fault_n idle", fault_n, 1);
      end
    end
    quiet();

    for (int ch = 0; ch < NC; ch++) begin
      // R2/R3: sustained short, flag at edge SDG, then PWM
      cmd_on = 4'(1 << ch); drain_hi = '1;
      for (int k = 1; k <= SDG + 2 * PER + 3; k++) begin
        logic f, d;
        step();
        f = (k >= SDG);
        d = (k < SDG) ? 1'b1 : (((k - SDG) % PER) < ON);
        chk("R2 short flag", load_flt, f ? (1 << ch) : 0);
        chk("R3 pwm drive", drive, d ? (1 << ch) : 0);
        chk("R9 fault_n short", fault_n, !f);
      end
      // R4: command off clears at next edge
      cmd_on = '0;
      step();
      chk("R4 off clears", load_flt, 0);
      chk("R4 off drive", drive, 0);
      quiet();

      // R4: drain recovers during off phase; flag holds until next on phase
      cmd_on = 4'(1 << ch); drain_hi = '1;
      for (int k = 1; k <= SDG + 4; k++) step();
      drain_hi = ~4'(1 << ch);
      for (int k = SDG + 5; k <= SDG + PER + 3; k++) begin
        logic f, d;
        step();
        f = (k <= SDG + PER);
        d = f ? (((k - SDG) % PER) < ON) : 1'b1;
        chk("R4 recover flag", load_flt, f ? (1 << ch) : 0);
        chk("R4 recover drive", drive, d ? (1 << ch) : 0);
      end
      quiet();

      // R2: bursts of SDG-1 never flag; a miss restarts the count
      cmd_on = 4'(1 << ch);
      for (int r = 0; r < 3; r++) begin
        drain_hi = '1;
        for (int k = 1; k < SDG; k++) begin
          step();
          chk("R2 glitch no flag", load_flt, 0);
          chk("R2 glitch drive", drive, 1 << ch);
        end
        drain_hi = ~4'(1 << ch);
        step();
        chk("R2 glitch gap", load_flt, 0);
      end
      quiet();

      // R5/R6: open load
      drain_hi = ~4'(1 << ch);
      for (int k = 1; k <= ODG + 4; k++) begin
        step();
        chk("R5 open flag", load_flt, (k >= ODG) ? (1 << ch) : 0);
        chk("R6 open drive", drive, 0);
        chk("R9 fault_n open", fault_n, !(k >= ODG));
      end
      drain_hi = '1;
      step();
      chk("R5 open clear", load_flt, 0);
      chk("R9 fault_n clear", fault_n, 1);

      // R5: turn-off transient shorter than ODG is not reported
      cmd_on = 4'(1 << ch); drain_hi = ~4'(1 << ch);
      step(); step();
      cmd_on = '0;
      for (int k = 1; k < ODG; k++) begin
        step();
        chk("R5 transient", load_flt, 0);
        chk("R1 turned off", drive, 0);
      end
      drain_hi = '1;
      step();
      chk("R5 transient end", load_flt, 0);
      quiet();
    end

    // R7/R8: battery faults, each comparator in turn
    for (int b = 0; b < 2; b++) begin
      cmd_on = 4'b0001; drain_hi = 4'b1101;
      for (int k = 1; k <= SDG; k++) step();
      chk("R2 pre-battery faults", load_flt, 4'b0011);
      bat_ov = (b == 0); bat_uv = (b == 1);
      cmd_on = '1; drain_hi = '1;
      for (int k = 1; k <= SDG + 3; k++) begin
        step();
        chk("R7 battery drive", drive, 0);
        chk("R7 battery fault_n", fault_n, 0);
        chk("R8 battery mask", load_flt, 0);
      end
      bat_ov = 1'b0; bat_uv = 1'b0;
      for (int k = 1; k <= SDG; k++) begin
        step();
        chk("R8 restart count", load_flt, (k >= SDG) ? 4'hF : 4'h0);
        chk("R7 resume drive", drive, 4'hF);
      end
      quiet();
      cmd_on = '1; drain_hi = '0;
      step();
      chk("R8 resume normal", drive, 4'hF);
      chk("R9 resume flag", fault_n, 1);
      quiet();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule